// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pin Overrides

This block is an eight-bit (by default) general-purpose I/O port placed on a simple register bus. Software sees three addressable views. The direction register sets each pin's direction. The output latch holds the values that pins drive. The pin view returns the level currently present on the pins. Each pin has a tri-state pair, a drive value and a drive enable, which the pad ring turns into a real bidirectional pad. Incoming pin levels pass through a two-stage synchronizer before software can read them.

Two outside agents can take a pin away from software without changing any software-visible register:

- **Peripheral override.** An attached peripheral can force one pin at a time, setting its direction and its drive value.
- **Memory-bus mode.** An external memory-bus controller can take over the whole port, except one fixed pin that always remains ordinary I/O.

Because overrides act only at the pin, software can read-modify-write the direction register at any time and never picks up the override values.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the direction register reads all ones and the output latch reads zero. In that state, with no override active, every `pin_oe` bit is 0.
- R2: A write strobe with address 0 (pin view) or address 1 (latch view) loads `reg_wdata` into the output latch on that clock edge. A read at address 1 returns the stored latch value, not the pin level.
- R3: A write strobe with address 2 loads `reg_wdata` into the direction register on that clock edge. A read at address 2 returns the stored direction value.
- R4: A read at address 0 returns `pin_in` as it was sampled two rising clock edges earlier. The synchronizer stages clear to zero on reset.
- R5: Consider a pin with no override, outside memory-bus mode. Direction bit 1 makes it an input (`pin_oe` = 0). Direction bit 0 makes it drive its latch bit (`pin_oe` = 1, `pin_out` = latch bit).
- R6: Consider a pin with `per_ovr_en` set, outside memory-bus mode. Its `pin_oe` is the inverse of `per_ovr_dir` (1 means input) and its `pin_out` is `per_ovr_val`. The direction register changes only on a direction write, never because of an override.
- R7: While `bus_mode` is 1, every pin except pin `FREE_PIN` (default 5) takes `pin_oe` from `bus_oe` and `pin_out` from `bus_out`. Pin `FREE_PIN` keeps its peripheral or software control.
- R8: Control priority is fixed: memory-bus mode first, then the peripheral override, then the software registers. A pin claimed by both the bus and a peripheral follows the bus.
- R9: Address 3 is unused. Reads there return zero, and writes there change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 pin view, 1 latch, 2 direction, 3 unused |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | WIDTH | Write data |
| reg_rdata | output | WIDTH | Read data, combinational on `reg_addr` |
| pin_in | input | WIDTH | Raw pin levels from the pads |
| pin_out | output | WIDTH | Value to drive on each pin |
| pin_oe | output | WIDTH | Drive enable per pin, 1 = drive |
| per_ovr_en | input | WIDTH | Peripheral override enable per pin |
| per_ovr_dir | input | WIDTH | Peripheral direction per pin, 1 = input |
| per_ovr_val | input | WIDTH | Peripheral drive value per pin |
| bus_mode | input | 1 | Memory-bus mode enable |
| bus_oe | input | WIDTH | Bus controller drive enable per pin |
| bus_out | input | WIDTH | Bus controller drive value per pin |

## Verification
A corrupted latch or direction bit shows up on the next read of address 1 or 2. If the affected pin is under software control, it also shows up at once on `pin_oe` or `pin_out`. A synchronizer fault shows as the address-0 read data being misaligned with `pin_in` by exactly the wrong number of cycles. A priority mistake is seen on the very cycle the conflicting override inputs are applied. The reference model in the bench is compared against every output on every clock, so each of these faults is reported within one or two cycles of its cause.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADR_PINS  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_LATCH = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DIR   = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_NONE  = 2'd3;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q
);
  // Both the pin view and the latch view write the same latch.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (wr) begin
      case (addr)
        ADR_PINS, ADR_LATCH: lat_q <= wdata;
        ADR_DIR:             dir_q <= wdata;
        default:             ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
  parameter int WIDTH    = 8,
  parameter int FREE_PIN = 5
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] per_ovr_en,
  input  logic [WIDTH-1:0] per_ovr_dir,
  input  logic [WIDTH-1:0] per_ovr_val,
  input  logic             bus_mode,
  input  logic [WIDTH-1:0] bus_oe,
  input  logic [WIDTH-1:0] bus_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam bit BUS_OWNS = (i != FREE_PIN);
    logic take_bus;
    assign take_bus = bus_mode & BUS_OWNS;

    // Priority: memory bus, then peripheral, then software registers.
    always_comb begin
      if (take_bus) begin
        pin_oe[i]  = bus_oe[i];
        pin_out[i] = bus_out[i];
      end else if (per_ovr_en[i]) begin
        pin_oe[i]  = ~per_ovr_dir[i];
        pin_out[i] = per_ovr_val[i];
      end else begin
        pin_oe[i]  = ~dir_q[i];
        pin_out[i] = lat_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int FREE_PIN    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [WIDTH-1:0]  reg_wdata,
  output logic [WIDTH-1:0]  reg_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:0]  per_ovr_en,
  input  logic [WIDTH-1:0]  per_ovr_dir,
  input  logic [WIDTH-1:0]  per_ovr_val,
  input  logic              bus_mode,
  input  logic [WIDTH-1:0]  bus_oe,
  input  logic [WIDTH-1:0]  bus_out
);
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] pin_sync;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .lat_q(lat_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  gpio_port_mux #(.WIDTH(WIDTH), .FREE_PIN(FREE_PIN)) u_mux (
    .dir_q(dir_q), .lat_q(lat_q),
    .per_ovr_en(per_ovr_en), .per_ovr_dir(per_ovr_dir), .per_ovr_val(per_ovr_val),
    .bus_mode(bus_mode), .bus_oe(bus_oe), .bus_out(bus_out),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  always_comb begin
    case (reg_addr)
      ADR_PINS:  reg_rdata = pin_sync;
      ADR_LATCH: reg_rdata = lat_q;
      ADR_DIR:   reg_rdata = dir_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int FREE_PIN = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [WIDTH-1:0]  reg_wdata,
  input logic [WIDTH-1:0]  reg_rdata,
  input logic [WIDTH-1:0]  pin_in,
  input logic [WIDTH-1:0]  pin_out,
  input logic [WIDTH-1:0]  pin_oe,
  input logic [WIDTH-1:0]  per_ovr_en,
  input logic [WIDTH-1:0]  per_ovr_dir,
  input logic [WIDTH-1:0]  per_ovr_val,
  input logic              bus_mode,
  input logic [WIDTH-1:0]  bus_oe,
  input logic [WIDTH-1:0]  bus_out,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  lat_q
);
  localparam logic [WIDTH-1:0] BUS_MASK = ~(WIDTH'(1) << FREE_PIN);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == '1 && lat_q == '0)); // R1

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && (reg_addr == ADR_PINS || reg_addr == ADR_LATCH)) |=> (lat_q == $past(reg_wdata))); // R2

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_DIR) |=> (dir_q == $past(reg_wdata))); // R3

  AST_PIN_READ_LAG: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && reg_addr == ADR_PINS) |-> (reg_rdata == $past(pin_in, 2))); // R4

  AST_DIR_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == ADR_DIR) |=> $stable(dir_q)); // R6

  AST_PERIPH_PIN: assert property (@(posedge clk) disable iff (rst)
    !bus_mode |-> (((pin_oe ^ ~per_ovr_dir) & per_ovr_en) == '0 &&
                   ((pin_out ^ per_ovr_val) & per_ovr_en) == '0)); // R6

  AST_BUS_TAKES: assert property (@(posedge clk) disable iff (rst)
    bus_mode |-> ((pin_oe & BUS_MASK) == (bus_oe & BUS_MASK) &&
                  (pin_out & BUS_MASK) == (bus_out & BUS_MASK))); // R7

  AST_FREE_PIN_SW: assert property (@(posedge clk) disable iff (rst)
    (bus_mode && !per_ovr_en[FREE_PIN]) |->
      (pin_oe[FREE_PIN] == ~dir_q[FREE_PIN] && pin_out[FREE_PIN] == lat_q[FREE_PIN])); // R7

  AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADR_NONE) |=> ($stable(lat_q) && $stable(dir_q))); // R9

  AST_UNUSED_READ: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADR_NONE) |-> (reg_rdata == '0)); // R9
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .FREE_PIN(FREE_PIN)) u_chk (.*);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int W = 8;
  localparam int FREE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]   reg_addr = '0;
  logic         reg_wr = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out, pin_oe;
  logic [W-1:0] per_ovr_en = '0, per_ovr_dir = '0, per_ovr_val = '0;
  logic         bus_mode = 1'b0;
  logic [W-1:0] bus_oe = '0, bus_out = '0;

  always #10 clk = ~clk;

  gpio_port #(.WIDTH(W), .FREE_PIN(FREE)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .per_ovr_en(per_ovr_en), .per_ovr_dir(per_ovr_dir), .per_ovr_val(per_ovr_val),
    .bus_mode(bus_mode), .bus_oe(bus_oe), .bus_out(bus_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [W-1:0] m_dir = '1, m_lat = '0;
  logic [W-1:0] hist [$];

  always @(posedge clk) begin
    if (rst) begin
      m_dir <= '1;
      m_lat <= '0;
      hist = {'0, '0};
    end else begin
      hist.push_back(pin_in);
      if (hist.size() > 2) void'(hist.pop_front());
      if (reg_wr) begin
        if (reg_addr == 2'd0 || reg_addr == 2'd1) m_lat <= reg_wdata;
        else if (reg_addr == 2'd2) m_dir <= reg_wdata;
      end
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison of every output on every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [W-1:0] e_rd, e_oe, e_out;
      string rl, pl;
      case (reg_addr)
        2'd0: begin e_rd = (hist.size() == 2) ? hist[0] : '0; rl = "R4"; end
        2'd1: begin e_rd = m_lat; rl = "R2"; end
        2'd2: begin e_rd = m_dir; rl = "R3"; end
        default: begin e_rd = '0; rl = "R9"; end
      endcase
      for (int i = 0; i < W; i++) begin
        if (bus_mode && i != FREE) begin e_oe[i] = bus_oe[i]; e_out[i] = bus_out[i]; end
        else if (per_ovr_en[i]) begin e_oe[i] = ~per_ovr_dir[i]; e_out[i] = per_ovr_val[i]; end
        else begin e_oe[i] = ~m_dir[i]; e_out[i] = m_lat[i]; end
      end
      pl = bus_mode ? "R7" : ((per_ovr_en != '0) ? "R6" : "R5");
      chk(rl, reg_rdata, e_rd);
      chk(pl, pin_oe, e_oe);
      chk(pl, pin_out, e_out);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_at_neg(logic [1:0] a, string req, logic [W-1:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
    step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    // R1: reset state observed while reset is held
    reg_addr = 2'd2; @(negedge clk); chk("R1", reg_rdata, 8'hFF);
    chk("R1", pin_oe, 8'h00);
    reg_addr = 2'd1; @(negedge clk); chk("R1", reg_rdata, 8'h00);
    step();
    rst = 1'b0;
    rd_at_neg(2'd2, "R1", 8'hFF);
    // R2: both write addresses feed the latch
    wr(2'd1, 8'hA5);
    rd_at_neg(2'd1, "R2", 8'hA5);
    wr(2'd0, 8'h3C);
    rd_at_neg(2'd1, "R2", 8'h3C);
    // R3 and R5: direction 0xCF drives bits 5:4 only
    wr(2'd2, 8'hCF);
    reg_addr = 2'd2; @(negedge clk);
    chk("R3", reg_rdata, 8'hCF);
    chk("R5", pin_oe, 8'h30);
    chk("R5", pin_out, 8'h3C);
    step();
    // R4: pin view lags by two edges
    reg_addr = 2'd0;
    pin_in = 8'h5A; step();
    @(negedge clk); chk("R4", reg_rdata, 8'h00);
    step();
    @(negedge clk); chk("R4", reg_rdata, 8'h5A);
    pin_in = 8'hC3; step(3);
    // R9: unused address
    wr(2'd3, 8'h55);
    rd_at_neg(2'd3, "R9", 8'h00);
    rd_at_neg(2'd1, "R9", 8'h3C);
    rd_at_neg(2'd2, "R9", 8'hCF);
    // R6: peripheral override leaves direction register intact
    per_ovr_en = 8'h0F; per_ovr_dir = 8'h05; per_ovr_val = 8'h0A;
    reg_addr = 2'd2; @(negedge clk);
    chk("R6", pin_oe[3:0], 4'hA);
    chk("R6", reg_rdata, 8'hCF);
    step();
    wr(2'd2, reg_rdata ^ 8'h01);
    rd_at_neg(2'd2, "R6", 8'hCE);
    // R7 and R8: bus mode beats peripheral, free pin stays software
    per_ovr_en = 8'h08; per_ovr_dir = 8'h00; per_ovr_val = 8'h08;
    bus_mode = 1'b1; bus_oe = 8'hFF; bus_out = 8'h00;
    @(negedge clk);
    chk("R8", {7'b0, pin_out[3]}, 8'h00);
    chk("R7", {7'b0, pin_oe[FREE]}, 8'h01);
    chk("R7", {7'b0, pin_out[FREE]}, 8'h01);
    step();
    bus_mode = 1'b0; per_ovr_en = '0;
    step(2);
    // Mixed random traffic, checked by the reference model every clock
    for (int n = 0; n < 400; n++) begin
      reg_addr = 2'($urandom); reg_wr = 1'($urandom); reg_wdata = W'($urandom);
      pin_in = W'($urandom);
      per_ovr_en = W'($urandom) & W'($urandom); per_ovr_dir = W'($urandom);
      per_ovr_val = W'($urandom);
      bus_mode = ($urandom % 4) == 0; bus_oe = W'($urandom); bus_out = W'($urandom);
      step();
    end
    reg_wr = 1'b0;
    step(2);
    finish_run();
  end
endmodule